// File: doc/BRIEF.md
# Leading-Zero Output Range Scaler

This block prepares a wide two's-complement audio sample for a narrow digital-to-analog converter. Instead of always discarding the low-order bits, it measures how many redundant sign bits sit at the top of the sample. It then moves the sample up by 0 to 3 places, so that small signals keep more of their low-order detail. The 12 upper bits of the moved value leave as the converter word. A one-hot scale code goes with the word and tells an external analog attenuator to divide by 1, 2, 4 or 8, which undoes the shift.

Taken together, the word and the code form a small floating-point value: a sign, an 11-bit mantissa and a 2-bit exponent. The scaler always keeps two copies of the sign at the top of any shifted word. Full normalisation is never reached, so the attenuator only switches ranges for small signals. The datapath is combinational and ends in one output register with a synchronous active-low reset.

Top module: `range_scaler`

## Requirements
- R1: The leading-run length L counts the sign bit (bit 14) plus every bit directly below it that equals the sign bit, stopping at the first bit that differs. The rule is the same for positive and negative samples.
- R2: When L is 5 or more, the shift amount is 3.
- R3: When L is exactly 4, the shift amount is 2.
- R4: When L is exactly 3, the shift amount is 1.
- R5: When L is 2 or less, the shift amount is 0. In that case the top three bits of the output word are never all equal.
- R6: The output word equals bits [14:3] of the 15-bit sample shifted left by the shift amount, with zeros entering at the bottom. The low-order bits below bit 3 are truncated.
- R7: The scale code is exactly one-hot, and bit k is set for a shift of k. Bit 0 therefore selects divide-by-1 (no shift) and bit 3 selects divide-by-8 (shift of 3).
- R8: The signed output word multiplied by 2^(3-shift) equals the signed input with its lowest (3-shift) bits cleared, rounding toward minus infinity.
- R9: Bit 11 of the output word always equals the input sign bit. When the shift is 3, bit 10 of the word also equals bit 11.
- R10: The outputs register the result of the sample present at the previous rising clock edge. When rst_n is low at a rising edge, the word becomes 0 and the scale code becomes 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 15 | Two's-complement input sample |
| dac_word_o | output | 12 | Registered converter word (two's complement) |
| scale_o | output | 4 | Registered one-hot scale code, bit k means divide by 2^k |

## Verification
On every cycle, the assertions check that the scale code is one-hot and that the sign bit survives into the word. They also check the guard-bit structure: a shift of 3 leaves two equal top bits, and any smaller shift leaves no three equal top bits. They check the reset values as well. The bench sweeps all 32768 input samples and compares each word and code against a leading-run count and shift computed arithmetically. It also confirms that scaling the word back up reproduces the truncated input, which covers the exact shift thresholds at run lengths 2 to 5. These value-level relations lie outside what the per-cycle properties express.

// File: rtl/rs_pkg.sv
// Package: shared sizing constants for the output range scaler.
// Assumes the sample is wider than the converter word by at least the
// maximum shift, so no zero fill ever reaches the word from below bit 0.
package rs_pkg;
    parameter int unsigned RS_IN_W     = 15; // sample width
    parameter int unsigned RS_OUT_W    = 12; // converter word width
    parameter int unsigned RS_MAX_SH   = 3;  // largest left shift
    parameter int unsigned RS_GUARD    = 2;  // sign copies kept on top
endpackage

// File: rtl/rs_lead_count.sv
// Module: rs_lead_count
// Measures the run of leading bits equal to the sign bit (sign included)
// and turns it into a shift amount that keeps GUARD sign copies, clamped
// to MAX_SH. Purely combinational.
module rs_lead_count #(
    parameter int unsigned IN_W   = rs_pkg::RS_IN_W,
    parameter int unsigned MAX_SH = rs_pkg::RS_MAX_SH,
    parameter int unsigned GUARD  = rs_pkg::RS_GUARD,
    localparam int unsigned SH_W  = $clog2(MAX_SH + 1)
) (
    input  logic [IN_W-1:0] din,
    output logic [SH_W-1:0] shamt
);
    int run_len;
    int sh_val;
    logic run_on;

    // Count the leading run and clamp the resulting shift.
    always_comb begin
        run_len = 1;
        run_on  = 1'b1;
        for (int i = int'(IN_W) - 2; i >= 0; i--) begin
            if (run_on && (din[i] == din[IN_W-1])) begin
                run_len = run_len + 1;
            end else begin
                run_on = 1'b0;
            end
        end
        sh_val = run_len - int'(GUARD);
        if (sh_val < 0) begin
            sh_val = 0;
        end
        if (sh_val > int'(MAX_SH)) begin
            sh_val = int'(MAX_SH);
        end
        shamt = SH_W'(sh_val);
    end
endmodule

// File: rtl/rs_shifter.sv
// Module: rs_shifter
// Left-shifts the sample by 0..MAX_SH and keeps the top OUT_W bits.
// Each word bit is a mux over MAX_SH+1 candidate sample bits; candidates
// that would come from below bit 0 are zero. Purely combinational.
module rs_shifter #(
    parameter int unsigned IN_W   = rs_pkg::RS_IN_W,
    parameter int unsigned OUT_W  = rs_pkg::RS_OUT_W,
    parameter int unsigned MAX_SH = rs_pkg::RS_MAX_SH,
    localparam int unsigned SH_W  = $clog2(MAX_SH + 1),
    localparam int unsigned NSH   = MAX_SH + 1,
    localparam int unsigned DROP  = IN_W - OUT_W
) (
    input  logic [IN_W-1:0]  din,
    input  logic [SH_W-1:0]  shamt,
    output logic [OUT_W-1:0] dout
);
    logic [OUT_W-1:0][NSH-1:0] cand;

    for (genvar j = 0; j < OUT_W; j++) begin : g_bit
        for (genvar k = 0; k < NSH; k++) begin : g_cand
            localparam int SRC = j + int'(DROP) - k;
            if (SRC >= 0) begin : g_src
                // Route the sample bit that lands here for shift k.
                assign cand[j][k] = din[SRC];
            end else begin : g_zero
                // Shifted-in zero for this position.
                assign cand[j][k] = 1'b0;
            end
        end
        // Select the candidate named by the shift amount.
        assign dout[j] = cand[j][shamt];
    end
endmodule

// File: rtl/rs_scale_dec.sv
// Module: rs_scale_dec
// Decodes the shift amount into a one-hot scale code; line k asks the
// external attenuator to divide by 2^k. Purely combinational.
module rs_scale_dec #(
    parameter int unsigned MAX_SH = rs_pkg::RS_MAX_SH,
    localparam int unsigned SH_W  = $clog2(MAX_SH + 1),
    localparam int unsigned NSH   = MAX_SH + 1
) (
    input  logic [SH_W-1:0] shamt,
    output logic [NSH-1:0]  scale
);
    for (genvar k = 0; k < NSH; k++) begin : g_line
        // Raise line k only for a shift of exactly k.
        assign scale[k] = (shamt == SH_W'(k));
    end
endmodule

// File: rtl/range_scaler.sv
// Module: range_scaler (top)
// Turns a two's-complement sample into a converter word plus a one-hot
// range code, registered once. Assumes a single clock domain and a
// synchronous active-low reset; the input is sampled every cycle.
module range_scaler #(
    parameter int unsigned IN_W   = rs_pkg::RS_IN_W,
    parameter int unsigned OUT_W  = rs_pkg::RS_OUT_W,
    parameter int unsigned MAX_SH = rs_pkg::RS_MAX_SH,
    parameter int unsigned GUARD  = rs_pkg::RS_GUARD,
    localparam int unsigned SH_W  = $clog2(MAX_SH + 1),
    localparam int unsigned NSH   = MAX_SH + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  sample_i,
    output logic [OUT_W-1:0] dac_word_o,
    output logic [NSH-1:0]   scale_o
);
    logic [SH_W-1:0]  shamt;
    logic [OUT_W-1:0] word_nxt;
    logic [NSH-1:0]   scale_nxt;

    rs_lead_count #(.IN_W(IN_W), .MAX_SH(MAX_SH), .GUARD(GUARD)) u_cnt (
        .din   (sample_i),
        .shamt (shamt)
    );

    rs_shifter #(.IN_W(IN_W), .OUT_W(OUT_W), .MAX_SH(MAX_SH)) u_shf (
        .din   (sample_i),
        .shamt (shamt),
        .dout  (word_nxt)
    );

    rs_scale_dec #(.MAX_SH(MAX_SH)) u_dec (
        .shamt (shamt),
        .scale (scale_nxt)
    );

    // Output register: reset to zero word at unity range, else capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_word_o <= '0;
            scale_o    <= NSH'(1);
        end else begin
            dac_word_o <= word_nxt;
            scale_o    <= scale_nxt;
        end
    end
endmodule

// File: rtl/range_scaler_chk.sv
// Module: range_scaler_chk
// Per-cycle properties of the scaler outputs, bound into range_scaler.
module range_scaler_chk #(
    parameter int unsigned IN_W   = rs_pkg::RS_IN_W,
    parameter int unsigned OUT_W  = rs_pkg::RS_OUT_W,
    parameter int unsigned MAX_SH = rs_pkg::RS_MAX_SH,
    localparam int unsigned NSH   = MAX_SH + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  sample_i,
    input logic [OUT_W-1:0] dac_word_o,
    input logic [NSH-1:0]   scale_o
);
    // R7: exactly one scale line is active.
    p_onehot_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(scale_o) == 1);

    // R9: the word carries the sign of the sample captured last edge.
    p_sign_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dac_word_o[OUT_W-1] == $past(sample_i[IN_W-1])));

    // R9: the largest shift still leaves two equal sign bits on top.
    p_guard_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && scale_o[MAX_SH]) |->
            (dac_word_o[OUT_W-1] == dac_word_o[OUT_W-2]));

    // R5: below the largest shift, no three equal bits remain on top.
    p_no_spare_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !scale_o[MAX_SH]) |->
            !((dac_word_o[OUT_W-1] == dac_word_o[OUT_W-2]) &&
              (dac_word_o[OUT_W-2] == dac_word_o[OUT_W-3])));

    // R10: a reset edge yields a zero word at unity range.
    p_reset_val_r10: assert property (@(posedge clk)
        !rst_n |=> (dac_word_o == '0 && scale_o == NSH'(1)));
endmodule

bind range_scaler range_scaler_chk #(
    .IN_W(IN_W), .OUT_W(OUT_W), .MAX_SH(MAX_SH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_i   (sample_i),
    .dac_word_o (dac_word_o),
    .scale_o    (scale_o)
);

// File: tb/range_scaler_tb.sv
`timescale 1ns/1ps
module range_scaler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] sample_i = '0;
    logic [11:0] dac_word_o;
    logic [3:0]  scale_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    range_scaler u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (sample_i),
        .dac_word_o (dac_word_o),
        .scale_o    (scale_o)
    );

    always #2 clk = ~clk; // 250 MHz

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Leading run length including the sign bit (R1).
    function automatic int run_len(input logic [14:0] s);
        int l = 1;
        for (int i = 13; i >= 0; i--) begin
            if (s[i] != s[14]) break;
            l++;
        end
        return l;
    endfunction

    function automatic int exp_shift(input logic [14:0] s);
        int l = run_len(s);
        if (l >= 5) return 3;
        if (l == 4) return 2;
        if (l == 3) return 1;
        return 0;
    endfunction

    function automatic int shift_of(input logic [3:0] sc);
        case (sc)
            4'b0001: return 0;
            4'b0010: return 1;
            4'b0100: return 2;
            4'b1000: return 3;
            default: return -1;
        endcase
    endfunction

    // Full check of one captured sample against the requirements.
    task automatic check_sample(input logic [14:0] s);
        int sh = exp_shift(s);
        logic [14:0] moved = s << sh;
        int sv = int'($signed(s));
        int wv = int'($signed(dac_word_o));
        int keep = 3 - sh;
        string tag;
        case (sh)
            3: tag = "R2 shift";
            2: tag = "R3 shift";
            1: tag = "R4 shift";
            default: tag = "R5 shift";
        endcase
        chk(tag, shift_of(scale_o), sh);
        chk("R7 scale code", int'(scale_o), 1 << sh);
        chk("R6 word", int'(dac_word_o), int'(moved[14:3]));
        chk("R8 reconstruct", wv * (1 << keep), (sv >>> keep) <<< keep);
        chk("R9 sign", int'(dac_word_o[11]), int'(s[14]));
    endtask

    // Drive at a falling edge, check at the next falling edge (R10 latency).
    task automatic apply(input logic [14:0] s);
        sample_i = s;
        @(negedge clk);
        check_sample(s);
    endtask

    initial begin
        // R10: reset state after a reset edge.
        sample_i = 15'h7C00;
        repeat (3) @(negedge clk);
        chk("R10 reset word", int'(dac_word_o), 0);
        chk("R10 reset scale", int'(scale_o), 1);
        rst_n = 1'b1;

        // Exhaustive sweep of every sample value.
        for (int v = 0; v < 32768; v++) begin
            apply(15'(v));
        end

        // R1: run counting treats positive and negative alike.
        apply(15'h0400);
        chk("R1 pos run L=4 word", int'(dac_word_o), 12'h200);
        chk("R1 pos run L=4 scale", int'(scale_o), 4'b0100);
        apply(15'h7C00);
        chk("R1 neg run L=5 word", int'(dac_word_o), 12'hC00);
        chk("R1 neg run L=5 scale", int'(scale_o), 4'b1000);
        apply(15'h7800);
        chk("R1 neg run L=4 word", int'(dac_word_o), 12'hC00);
        chk("R3 neg L=4 scale", int'(scale_o), 4'b0100);
        // R2: zero and minus one take the largest shift.
        apply(15'h0000);
        chk("R2 zero scale", int'(scale_o), 4'b1000);
        apply(15'h7FFF);
        chk("R2 minus one word", int'(dac_word_o), 12'hFFF);
        // R5: full-scale extremes stay unshifted.
        apply(15'h3FFF);
        chk("R5 max word", int'(dac_word_o), 12'h7FF);
        apply(15'h4000);
        chk("R5 min word", int'(dac_word_o), 12'h800);
        chk("R5 min scale", int'(scale_o), 4'b0001);

        // R10: reset in mid-run returns the reset values.
        sample_i = 15'h0001;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid-run reset word", int'(dac_word_o), 0);
        chk("R10 mid-run reset scale", int'(scale_o), 1);
        rst_n = 1'b1;
        apply(15'h0001);
        chk("R10 after reset scale", int'(scale_o), 4'b1000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule